// File: doc/BRIEF.md
# Double-Buffered GPIO Pattern Generator

This block plays 32-bit words out onto a small group of general purpose output pins. Software writes one word into each of two holding buffers. Each write marks its buffer as ready. The block is then put into pattern mode. From that point, every strobe pulse takes the next group of 1, 2 or 4 bits from the current word and drives it onto the chosen pins. Groups are taken starting from the least significant end of the word. Each group bit, called a lane, goes to a pin that software picks.

When the last group of a word has been sent, the block does three things. It releases that buffer by clearing its ready flag, it records a completion event, and it moves to the other buffer. Software refills the released buffer while the other one plays. If the other buffer is not ready when the switch happens, the block records an underrun. The pins then keep their last value until the missing word arrives. Three sticky event bits, with an enable mask, a clear pulse and a software set pulse, combine into one interrupt line.

Top module: `gpio_pattern_gen`

## Requirements
- R1: After reset, gpio_o, gpio_oe_o, buf_ready_o, int_status_o and irq_o are all zero, and buffer 0 is the first buffer to be played.
- R2: Pattern mode is on only when mode_i is 2'b01. With any other value, gpio_oe_o and gpio_o are zero. Strobes have no effect until mode_i is 2'b01 and both buffers have been ready together.
- R3: width_i selects the group size: 0 gives 1 bit, 1 gives 2 bits, and 2 or 3 give 4 bits. This makes 32, 16 or 8 strobes per word. Strobe number s takes the bits from s*size upward, and lane 0 is the lowest bit of the group.
- R4: The pins change on the clock edge that samples strobe_i high while playing. Between strobes they hold their value.
- R5: Lane k drives the pin numbered lane_pin_i[3k+2:3k] (3-bit fields), but only for lanes below the group size. In pattern mode gpio_oe_o is high exactly on those pins. All other pins have output enable low and value zero. If two lanes name the same pin, the higher lane wins.
- R6: When a word is used up, the ready flag of its buffer clears. Its done bit is set in the same edge: int_status_o bit 0 for buffer 0, bit 1 for buffer 1. Playback goes on from bit 0 of the other buffer.
- R7: If the other buffer is not ready when a word is used up, int_status_o bit 2 (underrun) is set. Later strobes are ignored, with the pins holding, until that buffer is loaded. Playback then resumes from its bit 0.
- R8: irq_o is the OR of int_status_o AND int_en_i. An int_clr_i bit clears its status bit on the next edge. An int_set_i bit, or a hardware event, sets its bit on the next edge and takes priority over a clear in the same cycle.
- R9: A load_i pulse writes load_data_i into the buffer chosen by load_sel_i and sets that buffer's ready flag.
- R10: Leaving pattern mode keeps the ready flags but resets playback. The next start begins at buffer 0, bit 0, and the pins read zero until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode select, 2'b01 turns pattern output on |
| width_i | input | 2 | Group size code |
| lane_pin_i | input | 12 | Target pin of each lane, 3 bits per lane |
| load_i | input | 1 | Buffer write pulse |
| load_sel_i | input | 1 | Buffer chosen by the write |
| load_data_i | input | 32 | Word to write |
| strobe_i | input | 1 | Output step pulse |
| int_en_i | input | 3 | Interrupt enable mask |
| int_set_i | input | 3 | Software set pulses for status bits |
| int_clr_i | input | 3 | Clear pulses for status bits |
| gpio_o | output | 8 | Pin values |
| gpio_oe_o | output | 8 | Pin output enables |
| buf_ready_o | output | 2 | Ready flag of each buffer |
| int_status_o | output | 3 | Done0, done1 and underrun status bits |
| irq_o | output | 1 | Interrupt request |

## Verification
A strobe, load, set or clear sampled at one rising edge shows up on the pins, ready flags and status bits right after that edge. A mode change also needs one edge. The start of playback needs one further edge after both ready flags and the mode are in place. irq_o follows the enable mask with no clock in between. The bench drives every input on the falling edge and checks the result on the next falling edge, so each check lands one register stage after its stimulus. For the enable mask it checks shortly after the change. Underrun holds and the two-buffer start rule are checked by issuing strobes that must not move the pins, then reading the pins before any further stimulus.

// File: rtl/gpg_pkg.sv
package gpg_pkg;
  // status bit positions
  localparam int ST_DONE0 = 0;
  localparam int ST_DONE1 = 1;
  localparam int ST_UNDER = 2;
  localparam int ST_BITS  = 3;

  // log2 of the group size for a width code (code 3 behaves as code 2)
  function automatic logic [1:0] width_log2(input logic [1:0] code);
    return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/gpg_unpack.sv
module gpg_unpack #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              advance_i,
  input  logic [1:0]        width_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [LANES-1:0]  lanes_o,
  output logic              last_o
);
  localparam int SW = $clog2(WORD_W);

  logic [SW-1:0]     step_q, step_d, last_step, shift;
  logic [LANES-1:0]  lane_q, lane_d, mask;
  logic [WORD_W-1:0] shifted;
  logic [1:0]        wlog;

  always_comb begin
    wlog      = gpg_pkg::width_log2(width_i);
    last_step = SW'((WORD_W >> wlog) - 1);
    shift     = SW'(step_q << wlog);
    shifted   = word_i >> shift;
    for (int k = 0; k < LANES; k++) mask[k] = (k < (1 << wlog));
    last_o    = (step_q == last_step);
    step_d    = step_q;
    lane_d    = lane_q;
    if (clear_i) begin
      step_d = '0;
      lane_d = '0;
    end else if (advance_i) begin
      step_d = last_o ? '0 : step_q + 1'b1;
      lane_d = shifted[LANES-1:0] & mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      lane_q <= '0;
    end else begin
      step_q <= step_d;
      lane_q <= lane_d;
    end
  end

  assign lanes_o = lane_q;

  assert_hold_between_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(advance_i) && !$past(clear_i) |-> $stable(lanes_o));
  assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i && last_o && !clear_i |=> step_q == '0);
endmodule

// File: rtl/gpg_pingpong.sv
module gpg_pingpong #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_on_i,
  input  logic              load_i,
  input  logic              load_sel_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              advance_i,
  input  logic              last_i,
  output logic [WORD_W-1:0] word_o,
  output logic [1:0]        ready_o,
  output logic              run_o,
  output logic [1:0]        done_evt_o,
  output logic              under_evt_o
);
  logic [WORD_W-1:0] buf_q [2];
  logic [1:0]        ready_q, ready_d;
  logic              active_q, active_d, started_q, started_d, exhaust;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q[b] <= '0;
      else if (load_i && load_sel_i == 1'(b)) buf_q[b] <= load_data_i;
    end
  end

  always_comb begin
    exhaust   = advance_i & last_i;
    for (int b = 0; b < 2; b++) begin
      done_evt_o[b] = exhaust && (active_q == 1'(b));
      ready_d[b]    = ready_q[b];
      if (load_i && load_sel_i == 1'(b)) ready_d[b] = 1'b1;
      else if (done_evt_o[b])            ready_d[b] = 1'b0;
    end
    under_evt_o = exhaust && !ready_q[~active_q] && !(load_i && load_sel_i == ~active_q);
    active_d    = !mode_on_i ? 1'b0 : (exhaust ? ~active_q : active_q);
    started_d   = mode_on_i && (started_q || (&ready_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= '0;
      active_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      ready_q   <= ready_d;
      active_q  <= active_d;
      started_q <= started_d;
    end
  end

  assign word_o  = buf_q[active_q];
  assign ready_o = ready_q;
  assign run_o   = mode_on_i && started_q && ready_q[active_q];

  assert_ready_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q[0]) |-> $past(exhaust && !active_q));
  assert_switch_on_exhaust_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_q) |-> $past(exhaust) || !$past(mode_on_i));
endmodule

// File: rtl/gpg_irq.sv
module gpg_irq #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] hw_evt_i,
  input  logic [NB-1:0] sw_set_i,
  input  logic [NB-1:0] sw_clr_i,
  input  logic [NB-1:0] enable_i,
  output logic [NB-1:0] status_o,
  output logic          irq_o
);
  logic [NB-1:0] status_q, status_d, raise;

  always_comb begin
    raise    = hw_evt_i | sw_set_i;
    status_d = (status_q & ~sw_clr_i) | raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & enable_i);

  assert_event_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    |raise |=> (status_q & $past(raise)) == $past(raise));
  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    |(sw_clr_i & ~raise) |=> (status_q & $past(sw_clr_i & ~raise)) == '0);
endmodule

// File: rtl/gpg_pinmap.sv
module gpg_pinmap #(
  parameter int NUM_PINS = 8,
  parameter int LANES    = 4,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                   mode_on_i,
  input  logic [1:0]             width_i,
  input  logic [LANES*PIN_W-1:0] lane_pin_i,
  input  logic [LANES-1:0]       lanes_i,
  output logic [NUM_PINS-1:0]    gpio_o,
  output logic [NUM_PINS-1:0]    oe_o
);
  logic [1:0]       wlog;
  logic [PIN_W-1:0] pin;

  always_comb begin
    wlog   = gpg_pkg::width_log2(width_i);
    gpio_o = '0;
    oe_o   = '0;
    pin    = '0;
    // ascending order: a higher lane overrides a lower one on the same pin
    for (int k = 0; k < LANES; k++) begin
      pin = lane_pin_i[k*PIN_W +: PIN_W];
      if (mode_on_i && (k < (1 << wlog))) begin
        gpio_o[pin] = lanes_i[k];
        oe_o[pin]   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_pattern_gen.sv
module gpio_pattern_gen #(
  parameter int NUM_PINS = 8,
  parameter int LANES    = 4,
  parameter int WORD_W   = 32,
  localparam int PIN_W   = $clog2(NUM_PINS),
  localparam int NB      = gpg_pkg::ST_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_i,
  input  logic [1:0]             width_i,
  input  logic [LANES*PIN_W-1:0] lane_pin_i,
  input  logic                   load_i,
  input  logic                   load_sel_i,
  input  logic [WORD_W-1:0]      load_data_i,
  input  logic                   strobe_i,
  input  logic [NB-1:0]          int_en_i,
  input  logic [NB-1:0]          int_set_i,
  input  logic [NB-1:0]          int_clr_i,
  output logic [NUM_PINS-1:0]    gpio_o,
  output logic [NUM_PINS-1:0]    gpio_oe_o,
  output logic [1:0]             buf_ready_o,
  output logic [NB-1:0]          int_status_o,
  output logic                   irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n, mode_on, run, advance, last, under_evt;
  logic [WORD_W-1:0] word;
  logic [LANES-1:0]  lanes;
  logic [1:0]        done_evt;
  logic [NB-1:0]     hw_evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode_on = (mode_i == 2'b01);
  assign advance = strobe_i && run;

  always_comb begin
    hw_evt                   = '0;
    hw_evt[gpg_pkg::ST_DONE0] = done_evt[0];
    hw_evt[gpg_pkg::ST_DONE1] = done_evt[1];
    hw_evt[gpg_pkg::ST_UNDER] = under_evt;
  end

  gpg_pingpong #(.WORD_W(WORD_W)) i_pingpong (
    .clk(clk), .rst_n(rst_int_n), .mode_on_i(mode_on), .load_i(load_i),
    .load_sel_i(load_sel_i), .load_data_i(load_data_i), .advance_i(advance),
    .last_i(last), .word_o(word), .ready_o(buf_ready_o), .run_o(run),
    .done_evt_o(done_evt), .under_evt_o(under_evt));

  gpg_unpack #(.WORD_W(WORD_W), .LANES(LANES)) i_unpack (
    .clk(clk), .rst_n(rst_int_n), .clear_i(!mode_on), .advance_i(advance),
    .width_i(width_i), .word_i(word), .lanes_o(lanes), .last_o(last));

  gpg_pinmap #(.NUM_PINS(NUM_PINS), .LANES(LANES)) i_pinmap (
    .mode_on_i(mode_on), .width_i(width_i), .lane_pin_i(lane_pin_i),
    .lanes_i(lanes), .gpio_o(gpio_o), .oe_o(gpio_oe_o));

  gpg_irq #(.NB(NB)) i_irq (
    .clk(clk), .rst_n(rst_int_n), .hw_evt_i(hw_evt), .sw_set_i(int_set_i),
    .sw_clr_i(int_clr_i), .enable_i(int_en_i), .status_o(int_status_o), .irq_o(irq_o));

  assert_idle_no_enable_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mode_on |-> gpio_oe_o == '0 && gpio_o == '0);
endmodule

// File: tb/test_gpio_pattern_gen.sv
module test_gpio_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i, width_i;
  logic [11:0] lane_pin_i;
  logic        load_i, load_sel_i, strobe_i;
  logic [31:0] load_data_i;
  logic [2:0]  int_en_i, int_set_i, int_clr_i;
  logic [7:0]  gpio_o, gpio_oe_o;
  logic [1:0]  buf_ready_o;
  logic [2:0]  int_status_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  gpio_pattern_gen i_gpio_pattern_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .width_i(width_i),
    .lane_pin_i(lane_pin_i), .load_i(load_i), .load_sel_i(load_sel_i),
    .load_data_i(load_data_i), .strobe_i(strobe_i), .int_en_i(int_en_i),
    .int_set_i(int_set_i), .int_clr_i(int_clr_i), .gpio_o(gpio_o),
    .gpio_oe_o(gpio_oe_o), .buf_ready_o(buf_ready_o),
    .int_status_o(int_status_o), .irq_o(irq_o));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_i = 2'b00; width_i = 2'd0; lane_pin_i = '0;
    load_i = 0; load_sel_i = 0; load_data_i = '0; strobe_i = 0;
    int_en_i = '0; int_set_i = '0; int_clr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input logic b, input logic [31:0] w);
    load_i = 1; load_sel_i = b; load_data_i = w;
    @(negedge clk);
    load_i = 0;
  endtask

  task automatic strobe();
    strobe_i = 1;
    @(negedge clk);
    strobe_i = 0;
  endtask

  function automatic int gsize(input logic [1:0] wd);
    return (wd == 2'd0) ? 1 : (wd == 2'd1) ? 2 : 4;
  endfunction

  // pin image for a lane value, mapping and width (mode assumed on)
  task automatic exp_map(input logic [3:0] ln, input logic [1:0] wd, input logic [11:0] sel,
                         output logic [7:0] g, output logic [7:0] oe);
    g = '0; oe = '0;
    for (int k = 0; k < gsize(wd); k++) begin
      g[sel[k*3 +: 3]]  = ln[k];
      oe[sel[k*3 +: 3]] = 1'b1;
    end
  endtask

  task automatic play(input logic [31:0] w, input int n, input string tag);
    logic [7:0] g, oe;
    int gs;
    gs = gsize(width_i);
    for (int s = 0; s < n; s++) begin
      strobe();
      exp_map(4'((w >> (s * gs)) & ((1 << gs) - 1)), width_i, lane_pin_i, g, oe);
      chk(gpio_o, g, tag);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(gpio_o, 0, "R1 gpio");
    chk(gpio_oe_o, 0, "R1 oe");
    chk(buf_ready_o, 0, "R1 ready");
    chk(int_status_o, 0, "R1 status");
    chk(irq_o, 0, "R1 irq");
  endtask

  task automatic t_no_start();
    do_reset();
    width_i = 2'd0; lane_pin_i = 12'h000;
    mode_i = 2'b01;
    load(0, 32'h0000_0001);
    repeat (2) @(negedge clk);
    repeat (3) strobe();
    chk(gpio_o, 0, "R2 one buffer ready, no output");
    chk(buf_ready_o, 2'b01, "R9 ready set by load");
    mode_i = 2'b10;
    load(1, 32'h0);
    @(negedge clk);
    chk(gpio_oe_o, 0, "R2 mode 10 oe low");
    strobe();
    chk(gpio_o, 0, "R2 mode 10 no output");
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    chk(gpio_oe_o, 8'h01, "R5 oe on lane0 pin");
    strobe();
    chk(gpio_o, 8'h01, "R9 starts at buffer 0 bit 0");
  endtask

  task automatic t_width1();
    logic [7:0] held;
    do_reset();
    width_i = 2'd0; lane_pin_i = 12'h005;
    load(0, 32'hA5C3_0F96);
    load(1, 32'h1234_8001);
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    chk(gpio_oe_o, 8'h20, "R5 single lane oe");
    play(32'hA5C3_0F96, 32, "R3 width1 word0");
    chk(buf_ready_o, 2'b10, "R6 buffer0 released");
    chk(int_status_o, 3'b001, "R6 done0 set");
    play(32'h1234_8001, 5, "R6 continues in buffer1");
    held = gpio_o;
    repeat (3) @(negedge clk);
    chk(gpio_o, held, "R4 hold without strobe");
  endtask

  task automatic t_width4();
    do_reset();
    width_i = 2'd2; lane_pin_i = 12'hD10;
    load(0, 32'h9E37_79B9);
    load(1, 32'h0);
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    chk(gpio_oe_o, 8'h55, "R5 four lanes oe");
    play(32'h9E37_79B9, 8, "R3 width4 eight steps");
    chk(int_status_o, 3'b001, "R3 word used after 8 steps");
  endtask

  task automatic t_width2_collide();
    do_reset();
    width_i = 2'd1; lane_pin_i = 12'h3DB;
    load(0, 32'h6C1B_D2E4);
    load(1, 32'h0);
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    chk(gpio_oe_o, 8'h08, "R5 unused lanes not driven");
    play(32'h6C1B_D2E4, 16, "R5 higher lane wins, width2");
    chk(int_status_o, 3'b001, "R3 word used after 16 steps");
  endtask

  task automatic t_underrun();
    do_reset();
    width_i = 2'd2; lane_pin_i = 12'h688;
    load(0, 32'h7654_3210);
    load(1, 32'hFEDC_BA98);
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    play(32'h7654_3210, 8, "R6 buffer0");
    play(32'hFEDC_BA98, 8, "R6 buffer1");
    chk(int_status_o, 3'b111, "R7 underrun flagged");
    chk(buf_ready_o, 2'b00, "R7 both released");
    repeat (2) strobe();
    chk(gpio_o, 8'h0F, "R7 strobes ignored, pins hold");
    load(0, 32'h0000_0005);
    strobe();
    chk(gpio_o, 8'h05, "R7 resumes at new word bit 0");
  endtask

  task automatic t_irq();
    do_reset();
    width_i = 2'd3; lane_pin_i = 12'h688;
    load(0, 32'h1357_9BDF);
    load(1, 32'h0);
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    play(32'h1357_9BDF, 8, "R3 width code 3 as 4 bits");
    chk(int_status_o, 3'b001, "R8 done0 status");
    chk(irq_o, 0, "R8 masked");
    int_en_i = 3'b001; #1;
    chk(irq_o, 1, "R8 enabled irq");
    int_clr_i = 3'b001;
    @(negedge clk);
    int_clr_i = 3'b000;
    chk(int_status_o, 3'b000, "R8 clear");
    chk(irq_o, 0, "R8 irq drops");
    int_set_i = 3'b100;
    @(negedge clk);
    int_set_i = 3'b000;
    chk(int_status_o, 3'b100, "R8 software set");
    int_en_i = 3'b100; #1;
    chk(irq_o, 1, "R8 set raises irq");
    int_set_i = 3'b010; int_clr_i = 3'b010;
    @(negedge clk);
    int_set_i = 3'b000; int_clr_i = 3'b000;
    chk(int_status_o, 3'b110, "R8 set beats clear");
  endtask

  task automatic t_mode_off();
    do_reset();
    width_i = 2'd1; lane_pin_i = 12'h008;
    load(0, 32'hC3A5_5A3C);
    load(1, 32'h0);
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    play(32'hC3A5_5A3C, 3, "R10 first steps");
    mode_i = 2'b00;
    @(negedge clk);
    chk(gpio_oe_o, 0, "R10 oe off");
    chk(buf_ready_o, 2'b11, "R10 ready kept");
    mode_i = 2'b01;
    repeat (2) @(negedge clk);
    chk(gpio_o, 0, "R10 pins zero before first strobe");
    play(32'hC3A5_5A3C, 16, "R10 restart from bit 0");
    chk(int_status_o, 3'b001, "R10 buffer0 done");
  endtask

  initial begin
    t_reset();
    t_no_start();
    t_width1();
    t_width4();
    t_width2_collide();
    t_underrun();
    t_irq();
    t_mode_off();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule